// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block turns slot-based access requests from an effects engine into physical addresses for delay-line sample memory used by reverb and chorus. Each slot holds a 20-bit offset and four control flags. The block adds the offset to a base counter that moves back by one location on every sample-frame strobe, then wraps the sum to the power-of-two size of the slot's memory region. Because the base moves every frame, a fixed offset reaches a different physical word each frame. Data written in one frame is therefore found again by an offset that is larger by the number of frames that have passed.

Slots are split into an internal range and an external range. Each range addresses its own memory region and has its own base counter. A slot table is loaded through a simple write port. The effects engine then issues at most one slot request per cycle, and the block answers one cycle later with a single memory operation: read, write or clear. A debug command returns both base counters to zero. Stored samples are 20 bits wide and are kept in 32-bit memory words. The memory itself sits outside the block.

Top module: `tdl_addr_gen`

## Requirements
- R1: After reset both base counters and both frame-start bases are zero, every slot configuration is zero, and all memory outputs are zero.
- R2: A slot word is decoded as: offset in bits 19:0, read in bit 20, write in bit 21, frame-aligned in bit 22, clear in bit 23. Slots 0 to INT_SLOTS-1 address the internal region (`mem_ext`=0). Slots INT_SLOTS to INT_SLOTS+EXT_SLOTS-1 address the external region (`mem_ext`=1).
- R3: A request accepted at one clock edge drives the memory outputs after that edge. The address is (offset + base) mod 2^AW of the slot's region, where base is the region's live counter value in the request cycle.
- R4: Each `frame_tick` decrements both live counters by one, modulo the region size. Without a tick or a zero command the counters hold their value.
- R5: `zero_cmd` sets both live counters to zero at the next edge and overrides a simultaneous `frame_tick`. If a tick occurs in the same cycle, the frame-start bases also become zero.
- R6: A frame-aligned slot uses the base captured at the most recent `frame_tick` (zero after reset). A later `zero_cmd` in the same frame does not change that captured base.
- R7: Clear outranks write, and write outranks read. A clear issues a write of zero. A write passes `req_wdata`. A read drives `mem_rd` with zero write data. `mem_rd` and `mem_wr` are never high together.
- R8: No memory cycle is issued, and every memory output is zero, for a cycle without a request, for a slot with no operation flag, or for a slot number outside both ranges. A configuration write to an out-of-range slot changes no slot.
- R9: A sample written through offset d is read back through offset d+k after k frame ticks in the same region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle sample-frame strobe |
| zero_cmd | input | 1 | Debug command that zeroes both base counters |
| cfg_we | input | 1 | Slot configuration write enable |
| cfg_slot | input | SLOT_W | Slot number to configure |
| cfg_word | input | 24 | Slot word: flags and offset |
| req_valid | input | 1 | Slot access request |
| req_slot | input | SLOT_W | Slot number requested |
| req_wdata | input | DATA_W | Sample to write for a write slot |
| mem_valid | output | 1 | Memory cycle issued |
| mem_ext | output | 1 | Selects the external region |
| mem_rd | output | 1 | Read cycle |
| mem_wr | output | 1 | Write cycle (including clear) |
| mem_addr | output | 20 | Word address within the region |
| mem_wdata | output | DATA_W | Write sample, zero for clear and read |

## Verification
The assertions assume a reset held low from time zero. They also assume `req_valid`, `frame_tick` and `zero_cmd` are driven to known values on every cycle after reset. The stimulus meets both conditions: the bench drives every input on the falling edge, holds each value for one full cycle, and always lists all inputs in a single step call. Random slot numbers extend past the configured range so that out-of-range requests and configuration writes occur. Ticks and zero commands are random and sometimes coincide.

// File: rtl/tdl_pkg.sv
// Shared types for the delay-line address generator.
// Assumes a 24-bit slot word whose field placement is fixed by the
// effects engine that writes it.
package tdl_pkg;
    localparam int OFF_W = 20;
    localparam int CFG_W = 24;

    // Slot word layout: bit 23 clear, 22 aligned, 21 write, 20 read, 19:0 offset.
    typedef struct packed {
        logic             clr;
        logic             algn;
        logic             wr;
        logic             rd;
        logic [OFF_W-1:0] off;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } mem_op_e;
endpackage

// File: rtl/tdl_base_ctr.sv
// Base counter for one memory region.
// Moves down by one location on each frame strobe and wraps at 2^AW.
// Also captures the new value as the frame-start base.
// Assumes frame_tick and zero_cmd are single-cycle pulses.
module tdl_base_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          zero_cmd,
    output logic [AW-1:0] live_base,
    output logic [AW-1:0] frame_base
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] next_dec;

    // Next value after one frame step.
    always_comb next_dec = live_base - ONE;

    // Live and frame-start base update; the zero command wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_base  <= '0;
            frame_base <= '0;
        end else if (zero_cmd) begin
            live_base <= '0;
            if (frame_tick) frame_base <= '0;
        end else if (frame_tick) begin
            live_base  <= next_dec;
            frame_base <= next_dec;
        end
    end
endmodule

// File: rtl/tdl_slot_table.sv
// Slot configuration storage, one register per slot.
// Has a write port and an asynchronous read port. Slot numbers past
// SLOTS-1 are never written, and on read they return an empty slot
// with rd_hit low.
module tdl_slot_table
    import tdl_pkg::*;
#(
    parameter int SLOTS  = 160,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_cfg_t         wr_cfg,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_cfg_t         rd_cfg,
    output logic              rd_hit
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    slot_cfg_t         cfg_q [SLOTS];
    logic [SLOT_W-1:0] rd_idx;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Per-slot register, loaded only when its own number is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cfg_q[s] <= '0;
            else if (wr_en && (wr_slot == SLOT_W'(s)))   cfg_q[s] <= wr_cfg;
        end
    end

    // Range check and guarded lookup.
    always_comb begin
        rd_hit = (rd_slot <= LAST);
        rd_idx = rd_hit ? rd_slot : '0;
        rd_cfg = rd_hit ? cfg_q[rd_idx] : '0;
    end
endmodule

// File: rtl/tdl_addr_calc.sv
// Combinational address and operation decode for one slot request.
// Chooses the live or frame-start base of the slot's region, adds the
// offset, wraps to the region size, and resolves flag priority.
// Assumes INT_AW and EXT_AW are at most OFF_W.
module tdl_addr_calc
    import tdl_pkg::*;
#(
    parameter int INT_AW = 10,
    parameter int EXT_AW = 11,
    parameter int DATA_W = 20
) (
    input  slot_cfg_t         cfg,
    input  logic              is_ext,
    input  logic [OFF_W-1:0]  live_int,
    input  logic [OFF_W-1:0]  live_ext,
    input  logic [OFF_W-1:0]  frame_int,
    input  logic [OFF_W-1:0]  frame_ext,
    input  logic [DATA_W-1:0] wdata_in,
    output mem_op_e           op,
    output logic [OFF_W-1:0]  addr,
    output logic [DATA_W-1:0] wdata_out
);
    localparam logic [OFF_W-1:0] INT_MASK = {OFF_W{1'b1}} >> (OFF_W - INT_AW);
    localparam logic [OFF_W-1:0] EXT_MASK = {OFF_W{1'b1}} >> (OFF_W - EXT_AW);

    logic [OFF_W-1:0] base_sel;
    logic [OFF_W-1:0] sum;

    // Base selection and modular address.
    always_comb begin
        if (cfg.algn) base_sel = is_ext ? frame_ext : frame_int;
        else          base_sel = is_ext ? live_ext  : live_int;
        sum  = cfg.off + base_sel;
        addr = sum & (is_ext ? EXT_MASK : INT_MASK);
    end

    // Flag priority: clear, then write, then read.
    always_comb begin
        if (cfg.clr) begin
            op        = OP_CLEAR;
            wdata_out = '0;
        end else if (cfg.wr) begin
            op        = OP_WRITE;
            wdata_out = wdata_in;
        end else if (cfg.rd) begin
            op        = OP_READ;
            wdata_out = '0;
        end else begin
            op        = OP_NONE;
            wdata_out = '0;
        end
    end
endmodule

// File: rtl/tdl_addr_gen.sv
// Top of the delay-line address generator.
// Holds the slot table and one base counter per region. Each request
// is answered with a registered memory operation one cycle later.
// Assumes at most one request per cycle and power-of-two region sizes.
module tdl_addr_gen
    import tdl_pkg::*;
#(
    parameter int INT_SLOTS = 128,
    parameter int EXT_SLOTS = 32,
    parameter int INT_AW    = 10,
    parameter int EXT_AW    = 11,
    parameter int DATA_W    = 20,
    parameter int SLOT_W    = $clog2(INT_SLOTS + EXT_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              zero_cmd,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_valid,
    output logic              mem_ext,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [OFF_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int                TOT_SLOTS = INT_SLOTS + EXT_SLOTS;
    localparam logic [SLOT_W-1:0] EXT_FIRST = SLOT_W'(INT_SLOTS);

    logic [OFF_W-1:0]  live_base  [2];
    logic [OFF_W-1:0]  frame_base [2];
    slot_cfg_t         slot_cfg;
    logic              slot_hit;
    logic              is_ext;
    mem_op_e           op;
    logic [OFF_W-1:0]  addr;
    logic [DATA_W-1:0] wdata;
    logic              issue;

    // One base counter per region; index 0 internal, 1 external.
    for (genvar r = 0; r < 2; r++) begin : g_region
        localparam int AW = (r == 0) ? INT_AW : EXT_AW;
        logic [AW-1:0] ctr_live;
        logic [AW-1:0] ctr_frame;

        tdl_base_ctr #(.AW(AW)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_tick (frame_tick),
            .zero_cmd   (zero_cmd),
            .live_base  (ctr_live),
            .frame_base (ctr_frame)
        );

        assign live_base[r]  = OFF_W'(ctr_live);
        assign frame_base[r] = OFF_W'(ctr_frame);
    end

    tdl_slot_table #(.SLOTS(TOT_SLOTS), .SLOT_W(SLOT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_slot (cfg_slot),
        .wr_cfg  (slot_cfg_t'(cfg_word)),
        .rd_slot (req_slot),
        .rd_cfg  (slot_cfg),
        .rd_hit  (slot_hit)
    );

    // Region of the requested slot.
    always_comb is_ext = (req_slot >= EXT_FIRST);

    tdl_addr_calc #(.INT_AW(INT_AW), .EXT_AW(EXT_AW), .DATA_W(DATA_W)) u_calc (
        .cfg       (slot_cfg),
        .is_ext    (is_ext),
        .live_int  (live_base[0]),
        .live_ext  (live_base[1]),
        .frame_int (frame_base[0]),
        .frame_ext (frame_base[1]),
        .wdata_in  (req_wdata),
        .op        (op),
        .addr      (addr),
        .wdata_out (wdata)
    );

    // A memory cycle needs a request, a slot in range, and an operation.
    always_comb issue = req_valid && slot_hit && (op != OP_NONE);

    // Registered memory command; all outputs zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !issue) begin
            mem_valid <= 1'b0;
            mem_ext   <= 1'b0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_valid <= 1'b1;
            mem_ext   <= is_ext;
            mem_rd    <= (op == OP_READ);
            mem_wr    <= (op == OP_WRITE) || (op == OP_CLEAR);
            mem_addr  <= addr;
            mem_wdata <= wdata;
        end
    end
endmodule

// File: rtl/tdl_addr_gen_chk.sv
// Property checker for the delay-line address generator, bound to the top.
// Assumes reset is low from time zero.
module tdl_addr_gen_chk #(
    parameter int INT_AW = 10,
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_tick,
    input logic              zero_cmd,
    input logic              req_valid,
    input logic              mem_valid,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [INT_AW-1:0] base_int
);
    localparam logic [INT_AW-1:0] ONE = {{(INT_AW-1){1'b0}}, 1'b1};

    assert_frame_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !zero_cmd) |=> (base_int == $past(base_int) - ONE));

    assert_base_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !zero_cmd) |=> $stable(base_int));

    assert_zero_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cmd |=> (base_int == '0));

    assert_single_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_rd != mem_wr));

    assert_read_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_wdata == '0));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mem_valid);
endmodule

bind tdl_addr_gen tdl_addr_gen_chk #(.INT_AW(INT_AW), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .zero_cmd   (zero_cmd),
    .req_valid  (req_valid),
    .mem_valid  (mem_valid),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .base_int   (live_base[0][INT_AW-1:0])
);

// File: tb/tdl_addr_gen_test.sv
// Self-checking bench: directed corner cases followed by seeded random steps.
// A lockstep model in the bench predicts every output, and a behavioural
// RAM holds the delay-line samples.
module tdl_addr_gen_test;
    localparam int NI = 128, NE = 32, TOT = NI + NE;
    localparam int IAW = 10, EAW = 11;
    localparam int IMASK = (1 << IAW) - 1, EMASK = (1 << EAW) - 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        frame_tick = 0, zero_cmd = 0, cfg_we = 0, req_valid = 0;
    logic [7:0]  cfg_slot = 0, req_slot = 0;
    logic [23:0] cfg_word = 0;
    logic [19:0] req_wdata = 0;
    logic        mem_valid, mem_ext, mem_rd, mem_wr;
    logic [19:0] mem_addr, mem_wdata;

    int total = 0, bad = 0;
    bit done = 0;

    bit [23:0] m_cfg [TOT];
    int m_base_i = 0, m_base_e = 0, m_lat_i = 0, m_lat_e = 0;
    bit [19:0] ram_i [1 << IAW];
    bit [19:0] ram_e [1 << EAW];

    tdl_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .zero_cmd(zero_cmd),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_slot(req_slot), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ext(mem_ext), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #10 clk = ~clk;

    function automatic int wrap_addr(input int off, input int base, input int mask);
        return (off + base) & mask;
    endfunction

    // Drive one cycle of inputs, predict, advance, compare.
    task automatic step(input bit ft, input bit zc, input bit cw, input bit [7:0] cs,
                        input bit [23:0] cwd, input bit rv, input bit [7:0] rs,
                        input bit [19:0] wd, input string tag);
        bit e_v = 0, e_x = 0, e_r = 0, e_w = 0;
        int e_a = 0, b = 0, nb;
        bit [19:0] e_d = 0;
        bit [23:0] c;
        frame_tick = ft; zero_cmd = zc; cfg_we = cw; cfg_slot = cs; cfg_word = cwd;
        req_valid = rv; req_slot = rs; req_wdata = wd;
        if (rv && rs < TOT) begin
            c   = m_cfg[rs];
            e_x = (rs >= NI);
            b   = c[22] ? (e_x ? m_lat_e : m_lat_i) : (e_x ? m_base_e : m_base_i);
            if (c[23])      begin e_w = 1; e_d = 0;  end
            else if (c[21]) begin e_w = 1; e_d = wd; end
            else if (c[20]) e_r = 1;
            e_v = e_r | e_w;
            if (e_v) e_a = wrap_addr(int'(c[19:0]), b, e_x ? EMASK : IMASK);
            if (!e_v) e_x = 0;
        end
        @(posedge clk);
        if (cw && cs < TOT) m_cfg[cs] = cwd;
        if (zc) begin
            m_base_i = 0; m_base_e = 0;
            if (ft) begin m_lat_i = 0; m_lat_e = 0; end
        end else if (ft) begin
            nb = (m_base_i - 1) & IMASK; m_base_i = nb; m_lat_i = nb;
            nb = (m_base_e - 1) & EMASK; m_base_e = nb; m_lat_e = nb;
        end
        @(negedge clk);
        total++;
        if (mem_valid !== e_v || mem_ext !== e_x || mem_rd !== e_r || mem_wr !== e_w ||
            mem_addr !== 20'(e_a) || mem_wdata !== e_d) begin
            bad++;
            $display("FAIL %s: got v=%b x=%b r=%b w=%b a=%h d=%h exp v=%b x=%b r=%b w=%b a=%h d=%h",
                     tag, mem_valid, mem_ext, mem_rd, mem_wr, mem_addr, mem_wdata,
                     e_v, e_x, e_r, e_w, 20'(e_a), e_d);
        end
        if (mem_valid === 1'b1 && mem_wr === 1'b1) begin
            if (mem_ext) ram_e[mem_addr[EAW-1:0]] = mem_wdata;
            else         ram_i[mem_addr[IAW-1:0]] = mem_wdata;
        end
    endtask

    task automatic idle(input bit ft, input bit zc, input string tag);
        step(ft, zc, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic cfg(input bit [7:0] s, input bit [23:0] w);
        step(0, 0, 1, s, w, 0, 0, 0, "R2");
    endtask

    task automatic req(input bit [7:0] s, input bit [19:0] d, input string tag);
        step(0, 0, 0, 0, 0, 1, s, d, tag);
    endtask

    // Delay-line read-back check against the behavioural RAM.
    task automatic check_ram(input bit [19:0] exp_d, input string tag);
        bit [19:0] got;
        got = mem_ext ? ram_e[mem_addr[EAW-1:0]] : ram_i[mem_addr[IAW-1:0]];
        total++;
        if (got !== exp_d) begin
            bad++;
            $display("FAIL %s: read-back got %h exp %h", tag, got, exp_d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        for (int i = 0; i < TOT; i++) m_cfg[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, and a cleared slot issues nothing
        idle(0, 0, "R1");
        req(3, 20'h12345, "R1");
        req(140, 20'h12345, "R1");

        // R3/R9: write at offset 7, three frames, read at offset 10
        cfg(5, 24'h200007);
        cfg(6, 24'h10000A);
        req(5, 20'hABCDE, "R3");
        idle(1, 0, "R4");
        idle(1, 0, "R4");
        idle(1, 0, "R4");
        req(6, 0, "R9");
        check_ram(20'hABCDE, "R9");

        // R2: external region write and delayed read
        cfg(130, 24'h2007F0);
        cfg(131, 24'h1007F2);
        req(130, 20'h0F00D, "R2");
        idle(1, 0, "R4");
        idle(1, 0, "R4");
        req(131, 0, "R9");
        check_ram(20'h0F00D, "R9");

        // R7: priority of clear over write over read
        cfg(8, 24'hB00010);
        cfg(9, 24'h300011);
        req(8, 20'h55555, "R7");
        req(9, 20'h66666, "R7");
        cfg(12, 24'h100011);
        req(12, 20'h77777, "R7");

        // R6/R5: aligned slot keeps frame-start base after a zero command
        cfg(10, 24'h500000);
        idle(0, 1, "R5");
        req(10, 0, "R6");
        req(6, 0, "R5");
        idle(1, 1, "R5");
        req(10, 0, "R6");
        idle(1, 0, "R4");
        req(10, 0, "R6");

        // R8: out-of-range slot, no alias of out-of-range config, empty flags
        req(200, 20'h1, "R8");
        step(0, 0, 1, 200, 24'h2000AA, 0, 0, 0, "R8");
        req(72, 20'h1, "R8");
        cfg(11, 24'h0000FF);
        req(11, 20'h1, "R8");
        step(0, 0, 0, 0, 0, 0, 5, 20'h1, "R8");

        // R4: base wraps below zero in both regions
        idle(0, 1, "R5");
        idle(1, 0, "R4");
        req(5, 20'h00042, "R4");
        req(131, 0, "R4");

        // R3: seeded random mix of configuration, requests, ticks and zeroing
        for (int n = 0; n < 4000; n++) begin
            bit [23:0] w;
            w = {4'($urandom), 20'($urandom)};
            step(($urandom % 8) == 0, ($urandom % 64) == 0, ($urandom % 4) == 0,
                 8'($urandom % 176), w, ($urandom % 4) != 0,
                 8'($urandom % 172), 20'($urandom), "R3");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule